// File: doc/BRIEF.md
# Multi-Mode Result Readout Bank

This block holds the most recent 12-bit conversion results of a three-pair, six-channel sampling front end. A host reads them back over a 16-bit parallel port. Results enter through a single-cycle write strobe that carries a pair code and the two values of that pair. Each 16-bit output word packs a valid flag, a 3-bit channel tag and the 12-bit result.

The host picks one of three read modes with a 3-bit selector. In direct mode it names a channel. In cycle mode it walks through all six channels in a fixed order. In queue mode it drains results in the order they were committed. A byte-mode input splits each word into two 8-bit reads for narrow host buses.

A result that arrives while the read strobe is low is parked in a one-deep holding slot and committed once the strobe returns high. This keeps the word under read stable. A sticky overflow flag records results lost to a full queue or to a full holding slot.

Top module: `result_readout_bank`

## Requirements
- R1: An output word carries bit 15 = valid (1 means data present), bits 14:12 = channel tag, and bits 11:0 = result with the MSB at bit 11. The channel tags are A0=000, A1=001, B0=010, B1=011, C0=100 and C1=101. The pair codes on `wr_pair_i` are A=00, B=01 and C=10; the X0 value travels on `wr_d0_i` and the X1 value on `wr_d1_i`.
- R2: With `sel_i` from 000 to 101, the word is the latest committed result of the channel whose tag equals `sel_i`. A channel that has not been written since reset reads 0x0000.
- R3: With `sel_i`=110, successive completed reads return A0, A1, B0, B1, C0, C1 and then A0 again. The pointer is at A0 after reset.
- R4: With `sel_i`=111, the word is the oldest queued result. Each commit queues X0 and then X1, and each completed read removes the oldest entry.
- R5: The queue holds six entries. A commit that finds fewer than two free entries, after any removal in the same cycle, is dropped whole and sets `ovf_o`. `ovf_o` stays set until reset. Direct and cycle modes still see the dropped result.
- R6: An empty queue reads 0x0000, and a completed read on an empty queue changes nothing.
- R7: A write that arrives while `rd_ni` is low is held and committed in the first cycle in which `rd_ni` is high. Until then the word under read does not change.
- R8: Only one write can be held. A further write while `rd_ni` is low and a write is already held is discarded and sets `ovf_o`.
- R9: With `byte_i` high, the first read of a word returns bits 7:0 on `dout_o[7:0]`, and the second read returns bits 15:8 there. `dout_o[15:8]` is 0 in byte mode. The cycle pointer and the queue advance only after the second read.
- R10: A read completes in the cycle where `rd_ni` is high after being low in the previous cycle, with `cs_ni` low. A strobe with `cs_ni` high advances nothing.
- R11: `oe_o` is high and `dout_o` carries the word only while both `cs_ni` and `rd_ni` are low. Otherwise `dout_o` is 0x0000.
- R12: An active-low `rst_ni` clears all stored results, the queue, the held write, the cycle pointer, the byte phase and `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Result write strobe, one cycle per pair |
| wr_pair_i | input | 2 | Pair code of the write (A=00, B=01, C=10) |
| wr_d0_i | input | 12 | Result for channel X0 of the pair |
| wr_d1_i | input | 12 | Result for channel X1 of the pair |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| sel_i | input | 3 | Channel address or mode (110 cycle, 111 queue) |
| byte_i | input | 1 | Split each word into two 8-bit reads |
| dout_o | output | 16 | Read data |
| oe_o | output | 1 | Read data enable |
| ovf_o | output | 1 | Sticky result-loss flag |

## Verification
The bench targets the queue boundary: a fourth pair written to a full queue must be dropped whole with the flag raised. A design that half-fills or overwrites the oldest entry would return a stray tag or lose A0. It also parks writes under a held read strobe. A design that commits at once would change the word mid-read, and one with a deeper holding slot would keep a second write that should have been lost. Byte-split cycle reads and chip-select-high strobes check that pointers move only on the second half of a real completed read; a premature advance would skip a channel. The reset pulse and the wrap from C1 to A0 close out the pointer and flag corners.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  localparam int DATA_W     = 12;
  localparam int TAG_W      = 3;
  localparam int WORD_W     = 1 + TAG_W + DATA_W;
  localparam int N_CH       = 6;
  localparam int PTR_W      = $clog2(N_CH);
  localparam int FIFO_DEPTH = 6;

  localparam logic [2:0] SEL_CYCLE = 3'b110;
  localparam logic [2:0] SEL_FIFO  = 3'b111;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t pack_word(input logic [TAG_W-1:0] tag, input logic [DATA_W-1:0] d);
    return {1'b1, tag, d};
  endfunction
endpackage

// File: rtl/rrb_defer.sv
module rrb_defer
  import rrb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        pair_i,
  input  logic [DATA_W-1:0] d0_i,
  input  logic [DATA_W-1:0] d1_i,
  input  logic              rd_ni,
  output logic              cm_v_o,
  output logic [1:0]        cm_pair_o,
  output logic [DATA_W-1:0] cm_d0_o,
  output logic [DATA_W-1:0] cm_d1_o,
  output logic              drop_o
);
  logic              pend_q;
  logic [1:0]        pair_q;
  logic [DATA_W-1:0] d0_q, d1_q;
  logic              load;

  always_comb begin
    cm_v_o    = rd_ni & (pend_q | wr_i);
    cm_pair_o = pend_q ? pair_q : pair_i;
    cm_d0_o   = pend_q ? d0_q : d0_i;
    cm_d1_o   = pend_q ? d1_q : d1_i;
    // strobe high: park only behind an older held write; strobe low: park if free
    load      = wr_i & (rd_ni ? pend_q : ~pend_q);
    drop_o    = wr_i & ~rd_ni & pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      pair_q <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
    end else begin
      if (rd_ni)     pend_q <= pend_q & wr_i;
      else if (wr_i) pend_q <= 1'b1;
      if (load) begin
        pair_q <= pair_i;
        d0_q   <= d0_i;
        d1_q   <= d1_i;
      end
    end
  end

  a_r7_no_commit_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ni |-> !cm_v_o);
  a_r7_release_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni && pend_q |-> cm_v_o && cm_pair_o == pair_q);
  a_r8_drop_keeps_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> pend_q && $stable(pair_q));
endmodule

// File: rtl/rrb_fifo.sv
module rrb_fifo
  import rrb_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  word_t w0_i,
  input  word_t w1_i,
  input  logic  pop_i,
  output word_t head_o,
  output logic  drop_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  word_t            mem_q [DEPTH];
  word_t            mem_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             pop_ok, fit;

  always_comb begin
    pop_ok = pop_i && (cnt_q != '0);
    base   = cnt_q - CNT_W'(pop_ok);
    fit    = (CNT_W'(DEPTH) - base) >= CNT_W'(2);
    drop_o = push_i && !fit;
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (pop_ok) mem_d[i] = (i == DEPTH - 1) ? '0 : mem_q[(i + 1) % DEPTH];
      if (push_i && fit && CNT_W'(i) == base)              mem_d[i] = w0_i;
      if (push_i && fit && CNT_W'(i) == base + CNT_W'(1))  mem_d[i] = w1_i;
    end
    cnt_d = base + ((push_i && fit) ? CNT_W'(2) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign head_o = (cnt_q != '0) ? mem_q[0] : '0;

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r5_drop_keeps_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o && !pop_i |=> $stable(cnt_q));
  a_r6_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == '0 && pop_i && !push_i |=> cnt_q == '0);
  a_r4_shift_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_ok && cnt_q > CNT_W'(1) |=> head_o == $past(mem_q[1]));
endmodule

// File: rtl/rrb_chan_bank.sv
module rrb_chan_bank
  import rrb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        pair_i,
  input  logic [DATA_W-1:0] d0_i,
  input  logic [DATA_W-1:0] d1_i,
  input  logic [2:0]        idx_i,
  output word_t             word_o
);
  word_t regs [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [TAG_W-1:0] TAG = TAG_W'(c);
    word_t r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           r_q <= '0;
      else if (wr_i && pair_i == TAG[2:1])   r_q <= pack_word(TAG, TAG[0] ? d1_i : d0_i);
    end
    assign regs[c] = r_q;
  end

  assign word_o = (idx_i < 3'(N_CH)) ? regs[idx_i] : '0;
endmodule

// File: rtl/result_readout_bank.sv
module result_readout_bank
  import rrb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        wr_pair_i,
  input  logic [DATA_W-1:0] wr_d0_i,
  input  logic [DATA_W-1:0] wr_d1_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic [2:0]        sel_i,
  input  logic              byte_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              oe_o,
  output logic              ovf_o
);
  logic              cm_v, def_drop, fifo_drop;
  logic [1:0]        cm_pair;
  logic [DATA_W-1:0] cm_d0, cm_d1;
  logic              rd_q, hi_q, done, adv, ovf_q;
  logic [PTR_W-1:0]  cyc_q;
  logic [2:0]        bank_idx;
  word_t             bank_word, fifo_word, word;

  rrb_defer u_defer (
    .clk_i, .rst_ni, .wr_i, .pair_i(wr_pair_i), .d0_i(wr_d0_i), .d1_i(wr_d1_i), .rd_ni,
    .cm_v_o(cm_v), .cm_pair_o(cm_pair), .cm_d0_o(cm_d0), .cm_d1_o(cm_d1), .drop_o(def_drop)
  );

  rrb_chan_bank u_bank (
    .clk_i, .rst_ni, .wr_i(cm_v), .pair_i(cm_pair), .d0_i(cm_d0), .d1_i(cm_d1),
    .idx_i(bank_idx), .word_o(bank_word)
  );

  rrb_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(cm_v),
    .w0_i(pack_word({cm_pair, 1'b0}, cm_d0)), .w1_i(pack_word({cm_pair, 1'b1}, cm_d1)),
    .pop_i(adv && sel_i == SEL_FIFO), .head_o(fifo_word), .drop_o(fifo_drop)
  );

  always_comb begin
    done     = ~rd_q & rd_ni & ~cs_ni;
    adv      = done & (~byte_i | hi_q);
    bank_idx = (sel_i == SEL_CYCLE) ? 3'(cyc_q) : sel_i;
    word     = (sel_i == SEL_FIFO) ? fifo_word : bank_word;
    oe_o     = ~cs_ni & ~rd_ni;
    dout_o   = '0;
    if (oe_o) dout_o = !byte_i ? word : hi_q ? {8'h00, word[15:8]} : {8'h00, word[7:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b1;
      hi_q  <= 1'b0;
      cyc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      rd_q  <= rd_ni;
      ovf_q <= ovf_q | def_drop | fifo_drop;
      if (done) hi_q <= byte_i & ~hi_q;
      if (adv && sel_i == SEL_CYCLE)
        cyc_q <= (cyc_q == PTR_W'(N_CH - 1)) ? '0 : cyc_q + PTR_W'(1);
    end
  end

  assign ovf_o = ovf_q;

  a_r1_pair_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> wr_pair_i != 2'b11);
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !byte_i && sel_i == SEL_CYCLE && cyc_q == PTR_W'(N_CH - 1) |=> cyc_q == '0);
  a_r9_low_half_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && byte_i && !hi_q |=> hi_q && $stable(cyc_q));
  a_r10_no_cs_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(cyc_q));
  a_r11_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> dout_o == '0);
  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: tb/result_readout_bank_bench.sv
`timescale 1ns/1ps
module result_readout_bank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [1:0]  wr_pair_i = '0;
  logic [11:0] wr_d0_i = '0, wr_d1_i = '0;
  logic        cs_ni = 1'b1, rd_ni = 1'b1;
  logic [2:0]  sel_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] dout_o;
  logic        oe_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  result_readout_bank u_result_readout_bank (
    .clk_i, .rst_ni, .wr_i, .wr_pair_i, .wr_d0_i, .wr_d1_i,
    .cs_ni, .rd_ni, .sel_i, .byte_i, .dout_o, .oe_o, .ovf_o
  );

  // behavioural reference model
  logic [15:0] bank [6];
  logic [15:0] mq [$];
  int          pq [$];
  bit          m_rdq, m_hi, m_ovf;
  int          m_cyc;

  task automatic m_commit(input int p, input int d0, input int d1);
    logic [15:0] w0, w1;
    w0 = {1'b1, 2'(p), 1'b0, 12'(d0)};
    w1 = {1'b1, 2'(p), 1'b1, 12'(d1)};
    bank[2*p] = w0;
    bank[2*p+1] = w1;
    if (mq.size() <= 4) begin mq.push_back(w0); mq.push_back(w1); end
    else m_ovf = 1;
  endtask

  always @(posedge clk_i) begin
    bit done, adv;
    int e;
    if (!rst_ni) begin
      foreach (bank[i]) bank[i] = '0;
      mq.delete(); pq.delete();
      m_rdq = 1; m_hi = 0; m_ovf = 0; m_cyc = 0;
    end else begin
      done = !m_rdq && rd_ni && !cs_ni;
      adv  = done && (!byte_i || m_hi);
      if (done) m_hi = byte_i ? !m_hi : 0;
      if (adv && sel_i == 3'd6) m_cyc = (m_cyc + 1) % 6;
      if (adv && sel_i == 3'd7 && mq.size() > 0) void'(mq.pop_front());
      if (rd_ni) begin
        if (pq.size() > 0) begin
          e = pq.pop_front();
          m_commit(e >> 24, (e >> 12) & 'hfff, e & 'hfff);
          if (wr_i) pq.push_back({6'd0, wr_pair_i, wr_d0_i, wr_d1_i});
        end else if (wr_i) m_commit(int'(wr_pair_i), int'(wr_d0_i), int'(wr_d1_i));
      end else if (wr_i) begin
        if (pq.size() == 0) pq.push_back({6'd0, wr_pair_i, wr_d0_i, wr_d1_i});
        else m_ovf = 1;
      end
      m_rdq = rd_ni;
    end
  end

  function automatic logic [15:0] m_out();
    logic [15:0] w;
    if (sel_i < 3'd6)       w = bank[sel_i];
    else if (sel_i == 3'd6) w = bank[m_cyc];
    else                    w = (mq.size() > 0) ? mq[0] : 16'h0;
    if (cs_ni || rd_ni) return 16'h0;
    if (byte_i) return m_hi ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
    return w;
  endfunction

  function automatic string m_req();
    if (cs_ni || rd_ni)  return "R11";
    if (byte_i)          return "R9";
    if (sel_i < 3'd6)    return "R2";
    if (sel_i == 3'd6)   return "R3";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk(m_req(), dout_o, m_out());
      chk("R11", 16'(oe_o), 16'(!cs_ni && !rd_ni));
      chk("R5", 16'(ovf_o), 16'(m_ovf));
    end
  end

  task automatic do_write(input int p, input int d0, input int d1);
    @(posedge clk_i); #1;
    wr_i = 1; wr_pair_i = 2'(p); wr_d0_i = 12'(d0); wr_d1_i = 12'(d1);
    @(posedge clk_i); #1;
    wr_i = 0;
  endtask

  task automatic do_read(input int s, input bit b, output logic [15:0] w);
    @(posedge clk_i); #1;
    sel_i = 3'(s); byte_i = b; cs_ni = 0;
    @(posedge clk_i); #1;
    rd_ni = 0;
    @(negedge clk_i);
    w = dout_o;
    @(posedge clk_i); #1;
    rd_ni = 1;
    @(posedge clk_i); #1;
    cs_ni = 1;
  endtask

  task automatic ghost_read(input int s);
    @(posedge clk_i); #1;
    sel_i = 3'(s); cs_ni = 1;
    @(posedge clk_i); #1;
    rd_ni = 0;
    @(posedge clk_i); #1;
    rd_ni = 1;
    @(posedge clk_i); #1;
  endtask

  task automatic pulse_reset();
    @(posedge clk_i); #1;
    rst_ni = 0;
    @(posedge clk_i); #1;
    rst_ni = 1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    logic [15:0] exp6 [6];
    exp6[0] = 16'h8123; exp6[1] = 16'h9456; exp6[2] = 16'hA789;
    exp6[3] = 16'hBABC; exp6[4] = 16'hC0F0; exp6[5] = 16'hDF0F;

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R12 reset state
    do_read(0, 0, w); chk("R12", w, 16'h0);
    do_read(7, 0, w); chk("R6", w, 16'h0);
    chk("R12", 16'(ovf_o), 16'h0);

    do_write(0, 'h123, 'h456);
    do_write(1, 'h789, 'hABC);
    do_write(2, 'h0F0, 'hF0F);

    // R1 format, R2 direct
    do_read(0, 0, w); chk("R1", w, 16'h8123);
    do_read(3, 0, w); chk("R2", w, 16'hBABC);
    do_read(5, 0, w); chk("R2", w, 16'hDF0F);

    // R3 cycle order with wrap
    for (int i = 0; i < 7; i++) begin
      do_read(6, 0, w); chk("R3", w, exp6[i % 6]);
    end

    // R4 queue order, R6 empty
    for (int i = 0; i < 6; i++) begin
      do_read(7, 0, w); chk("R4", w, exp6[i]);
    end
    do_read(7, 0, w); chk("R6", w, 16'h0);
    do_read(7, 0, w); chk("R6", w, 16'h0);

    // R5 overflow on fourth pair
    do_write(0, 'h123, 'h456);
    do_write(1, 'h789, 'hABC);
    do_write(2, 'h0F0, 'hF0F);
    chk("R5", 16'(ovf_o), 16'h0);
    do_write(0, 'h111, 'h222);
    @(negedge clk_i); chk("R5", 16'(ovf_o), 16'h1);
    do_read(0, 0, w); chk("R5", w, 16'h8111);
    for (int i = 0; i < 6; i++) begin
      do_read(7, 0, w); chk("R5", w, exp6[i]);
    end

    // R12 mid-run reset
    pulse_reset();
    @(negedge clk_i); chk("R12", 16'(ovf_o), 16'h0);
    do_read(1, 0, w); chk("R12", w, 16'h0);

    // R7 deferral, R8 single slot
    @(posedge clk_i); #1 sel_i = 3'd2; byte_i = 0; cs_ni = 0;
    @(posedge clk_i); #1 rd_ni = 0;
    do_write(1, 'h345, 'h678);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); chk("R7", dout_o, 16'h0);
    do_write(2, 'h555, 'h666);
    @(negedge clk_i); chk("R8", 16'(ovf_o), 16'h1);
    @(posedge clk_i); #1 rd_ni = 1;
    @(posedge clk_i); #1 cs_ni = 1;
    do_read(2, 0, w); chk("R7", w, 16'hA345);
    do_read(4, 0, w); chk("R8", w, 16'h0);
    do_read(7, 0, w); chk("R7", w, 16'hA345);

    // R9 byte mode in cycle mode (pointer at A0 after reset)
    do_write(0, 'h123, 'h456);
    do_read(6, 1, w); chk("R9", w, 16'h0023);
    do_read(6, 1, w); chk("R9", w, 16'h0081);
    do_read(6, 1, w); chk("R9", w, 16'h0056);
    do_read(6, 1, w); chk("R9", w, 16'h0094);
    do_read(6, 0, w); chk("R3", w, 16'hA345);

    // R10 strobe without chip select
    ghost_read(6);
    do_read(6, 0, w); chk("R10", w, 16'hB678);

    // R11 idle bus
    @(negedge clk_i); chk("R11", dout_o, 16'h0);
    chk("R11", 16'(oe_o), 16'h0);
    @(posedge clk_i); #1 cs_ni = 0; sel_i = 3'd0;
    @(negedge clk_i); chk("R11", dout_o, 16'h0);
    @(posedge clk_i); #1 cs_ni = 1;

    repeat (2) @(posedge clk_i);
    finish_run();
  end
endmodule